// File: doc/BRIEF.md
# Partitioned Saturating Packed Adder

This block adds or subtracts two 64-bit packed operands as a group of equal-width lanes. A lane-size select splits the word into eight 8-bit, four 16-bit, two 32-bit or one 64-bit lane. The datapath is a single segmented carry chain. Every lane runs the same operation in the same cycle, each on its own slice of the operands.

Each lane can produce the plain two's-complement wrapped result or a saturated result. Operands can be treated as signed or unsigned. A per-lane flag reports whenever the exact result does not fit in its lane. The result and flags are registered once, so they appear one clock after the operands are presented.

Top module: `simd_sat_adder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the result and all lane flags read zero.
- R2: The result and flags for inputs sampled at a rising clock edge appear on the outputs just after that edge and stay unchanged until the next rising edge.
- R3: The lane-size select encodes 0 = eight 8-bit lanes, 1 = four 16-bit lanes, 2 = two 32-bit lanes, 3 = one 64-bit lane. Lane k occupies result bits k*W to k*W+W-1, where W is the lane width.
- R4: No carry or borrow crosses a lane boundary in any mode.
- R5: With saturation off, each lane holds the exact sum or difference modulo 2^W.
- R6: With the subtract select at 1, each lane computes operand A minus operand B. With it at 0, each lane computes A plus B.
- R7: Flag bit k is 1 exactly when lane k's exact result (signed or unsigned, per the signed select) lies outside the lane's range, whether or not saturation is on. Flag bits at or above the lane count are 0.
- R8: With saturation and signed mode on, an overflowing lane holds its largest positive value (0x7F.. pattern) on positive overflow and its most negative value (0x80.. pattern) on negative overflow.
- R9: With saturation on and signed mode off, an overflowing add lane holds all ones and an underflowing subtract lane holds zero.
- R10: In the one-lane mode the block behaves as an ordinary 64-bit adder/subtractor, with the same flag and saturation rules at 64-bit width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset, synchronous to the clock |
| a_i | input | 64 | Packed operand A |
| b_i | input | 64 | Packed operand B |
| lane_sel_i | input | 2 | Lane size: 0=8, 1=16, 2=32, 3=64 bits |
| sub_i | input | 1 | 1 = A minus B, 0 = A plus B |
| signed_i | input | 1 | 1 = lanes are signed two's complement |
| sat_i | input | 1 | 1 = clamp overflowing lanes |
| res_o | output | 64 | Registered packed result |
| lane_ovf_o | output | 8 | Registered per-lane range-violation flags, bit k = lane k |

## Verification
Every result and every flag is due at the first rising edge after the operands and controls are applied; there is no other latency. The bench changes inputs on the falling edge and compares the outputs on the following falling edge, which is half a period after the rising edge that loads them. The latency check adds one more sample just before that rising edge, where the outputs must still show the previous operation.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

    localparam int DATA_W = 64;
    localparam int SEG_W  = 8;
    localparam int NSEG   = DATA_W / SEG_W;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [NSEG-1:0]   ovf;
    } pk_out_t;

    function automatic int unsigned segs_per_lane(input logic [1:0] mode);
        int unsigned n;
        n = 32'd1 << mode;
        if (n > NSEG) n = NSEG;
        return n;
    endfunction

endpackage

// File: rtl/pk_seg_adder.sv
module pk_seg_adder
    import simd_sat_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int SW   = SEG_W,
    localparam int NS  = W / SW
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_eff_i,
    input  logic          cin_i,
    input  logic [1:0]    mode_i,
    output logic [W-1:0]  sum_o,
    output logic [NS-1:0] cout_o
);

    always_comb begin
        int unsigned   spl;
        logic          c;
        logic [SW:0]   t;
        spl    = segs_per_lane(mode_i);
        c      = cin_i;
        t      = '0;
        sum_o  = '0;
        cout_o = '0;
        for (int i = 0; i < NS; i++) begin
            // carry chain is cut at every lane start; the lane carry-in is injected instead
            if ((i & (spl - 1)) == 0) c = cin_i;
            t = {1'b0, a_i[i*SW +: SW]} + {1'b0, b_eff_i[i*SW +: SW]} + {{SW{1'b0}}, c};
            sum_o[i*SW +: SW] = t[SW-1:0];
            cout_o[i]         = t[SW];
            c                 = t[SW];
        end
    end

endmodule

// File: rtl/pk_lane_sat.sv
module pk_lane_sat
    import simd_sat_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int SW   = SEG_W,
    localparam int NS  = W / SW
) (
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_eff_i,
    input  logic [W-1:0]  sum_i,
    input  logic [NS-1:0] cout_i,
    input  logic [1:0]    mode_i,
    input  logic          sub_i,
    input  logic          signed_i,
    input  logic          sat_i,
    output logic [W-1:0]  res_o,
    output logic [NS-1:0] lane_ovf_o
);

    always_comb begin
        int unsigned spl;
        int unsigned top;
        int unsigned msb;
        logic        sa, sb, sr, s_ovf, u_ovf, ov, pos;
        logic [SW-1:0] clamp;
        spl        = segs_per_lane(mode_i);
        res_o      = sum_i;
        lane_ovf_o = '0;
        for (int i = 0; i < NS; i++) begin
            top   = i | (spl - 1);
            msb   = top * SW + SW - 1;
            sa    = a_i[msb];
            sb    = b_eff_i[msb];
            sr    = sum_i[msb];
            s_ovf = (sa == sb) && (sr != sa);
            u_ovf = sub_i ? ~cout_i[top] : cout_i[top];
            ov    = signed_i ? s_ovf : u_ovf;
            pos   = ~sa;
            if (signed_i) begin
                if (i == int'(top)) clamp = {~pos, {(SW-1){pos}}};
                else                clamp = {SW{pos}};
            end else begin
                clamp = {SW{~sub_i}};
            end
            if (sat_i && ov) res_o[i*SW +: SW] = clamp;
            if (i == int'(top)) lane_ovf_o[i / spl] = ov;
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
    import simd_sat_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        lane_sel_i,
    input  logic              sub_i,
    input  logic              signed_i,
    input  logic              sat_i,
    output logic [DATA_W-1:0] res_o,
    output logic [NSEG-1:0]   lane_ovf_o
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] raw_sum;
    logic [NSEG-1:0]   seg_cout;
    logic [DATA_W-1:0] lane_res;
    logic [NSEG-1:0]   lane_ovf;
    pk_out_t           out_d, out_q;

    assign b_eff = sub_i ? ~b_i : b_i;

    pk_seg_adder #(.W(DATA_W), .SW(SEG_W)) u_adder (
        .a_i     (a_i),
        .b_eff_i (b_eff),
        .cin_i   (sub_i),
        .mode_i  (lane_sel_i),
        .sum_o   (raw_sum),
        .cout_o  (seg_cout)
    );

    pk_lane_sat #(.W(DATA_W), .SW(SEG_W)) u_sat (
        .a_i        (a_i),
        .b_eff_i    (b_eff),
        .sum_i      (raw_sum),
        .cout_i     (seg_cout),
        .mode_i     (lane_sel_i),
        .sub_i      (sub_i),
        .signed_i   (signed_i),
        .sat_i      (sat_i),
        .res_o      (lane_res),
        .lane_ovf_o (lane_ovf)
    );

    always_comb begin
        out_d     = out_q;
        out_d.res = lane_res;
        out_d.ovf = lane_ovf;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign res_o      = out_q.res;
    assign lane_ovf_o = out_q.ovf;

    // One-lane wrap add matches a plain 64-bit sum one cycle later
    assert_full_width_add_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(lane_sel_i == LANE_64 && !sub_i && !sat_i)
        |-> res_o == $past(a_i + b_i));

    // Flag bits above the lane count stay clear
    assert_upper_flags_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(lane_sel_i == LANE_32)
        |-> lane_ovf_o[NSEG-1:2] == '0);

    assert_single_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(lane_sel_i == LANE_64)
        |-> lane_ovf_o[NSEG-1:1] == '0);

    assert_usat_add_ones_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(lane_sel_i == LANE_64 && !sub_i && !signed_i && sat_i)
        && lane_ovf_o[0] |-> res_o == '1);

    assert_usat_sub_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(lane_sel_i == LANE_64 && sub_i && !signed_i && sat_i)
        && lane_ovf_o[0] |-> res_o == '0);

    assert_ssat_pos_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(lane_sel_i == LANE_64 && signed_i && sat_i && !a_i[DATA_W-1])
        && lane_ovf_o[0] |-> res_o == {1'b0, {(DATA_W-1){1'b1}}});

endmodule

// File: tb/simd_sat_adder_tb.sv
`timescale 1ns/1ps
module simd_sat_adder_tb;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] a = '0, b = '0;
    logic [1:0]  sel = '0;
    logic        sub = 1'b0, sgn = 1'b0, sat = 1'b0;
    logic [63:0] res;
    logic [7:0]  flg;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    simd_sat_adder u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .lane_sel_i(sel),
        .sub_i(sub), .signed_i(sgn), .sat_i(sat), .res_o(res), .lane_ovf_o(flg)
    );

    function automatic void model(input logic [63:0] xa, xb, input logic [1:0] m,
                                  input logic s, g, t,
                                  output logic [63:0] r, output logic [7:0] f);
        int w, n;
        w = 8 << m;
        n = 64 / w;
        r = '0;
        f = '0;
        for (int k = 0; k < n; k++) begin
            logic signed [67:0] x, y, e, lo, hi;
            logic [63:0] la, lb, mask;
            mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
            la = (xa >> (k * w)) & mask;
            lb = (xb >> (k * w)) & mask;
            x = la;
            y = lb;
            if (g) begin
                if (la[w-1]) x = x - (68'sd1 <<< w);
                if (lb[w-1]) y = y - (68'sd1 <<< w);
                lo = -(68'sd1 <<< (w - 1));
                hi = (68'sd1 <<< (w - 1)) - 68'sd1;
            end else begin
                lo = '0;
                hi = (68'sd1 <<< w) - 68'sd1;
            end
            e = s ? x - y : x + y;
            if (e > hi || e < lo) begin
                f[k] = 1'b1;
                if (t) e = (e > hi) ? hi : lo;
            end
            r = r | ((64'(e) & mask) << (k * w));
        end
    endfunction

    task automatic check(input string req, input logic [63:0] er, input logic [7:0] ef);
        checks++;
        if (res !== er || flg !== ef) begin
            fails++;
            $display("FAIL %s: res=%h flags=%b expected res=%h flags=%b", req, res, flg, er, ef);
        end
    endtask

    task automatic run_vec(input string req, input logic [63:0] xa, xb,
                           input logic [1:0] m, input logic s, g, t);
        logic [63:0] er;
        logic [7:0]  ef;
        @(negedge clk);
        a = xa; b = xb; sel = m; sub = s; sgn = g; sat = t;
        model(xa, xb, m, s, g, t, er, ef);
        @(negedge clk);
        check(req, er, ef);
    endtask

    task automatic t_reset_R1;
        a = '1; b = 64'h1; sel = 2'd0; sat = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, '0);
        rst_ni = 1'b1;
        #1 check("R1 after release", '0, '0);
    endtask

    task automatic t_latency_R2;
        logic [63:0] er;
        logic [7:0]  ef;
        run_vec("R2 setup", 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111, 2'd0, 0, 0, 0);
        @(negedge clk);
        a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h1; sel = 2'd3; sub = 0; sgn = 0; sat = 0;
        #1.5;
        check("R2 before edge", 64'h1213_1415_1617_1819, 8'h00);
        model(a, b, sel, sub, sgn, sat, er, ef);
        @(negedge clk);
        check("R2 after edge", er, ef);
    endtask

    task automatic t_isolation_R4;
        for (int m = 0; m < 4; m++) begin
            run_vec("R4 add carry cut", '1, 64'h0101_0101_0101_0101, 2'(m), 0, 0, 0);
            run_vec("R4 sub borrow cut", '0, 64'h0101_0101_0101_0101, 2'(m), 1, 0, 0);
        end
    endtask

    task automatic t_wrap_R5;
        run_vec("R5 8-bit wrap", 64'h80FF_7F01_C0DE_1234, 64'h80FF_0101_4022_EDCC, 2'd0, 0, 0, 0);
        run_vec("R3 16-bit lanes", 64'h80FF_7F01_C0DE_1234, 64'h80FF_0101_4022_EDCC, 2'd1, 0, 1, 0);
        run_vec("R3 32-bit lanes", 64'h80FF_7F01_C0DE_1234, 64'h80FF_0101_4022_EDCC, 2'd2, 0, 1, 0);
    endtask

    task automatic t_sub_R6;
        run_vec("R6 sub 8", 64'h0010_2030_4050_6070, 64'h0102_0304_0506_0708, 2'd0, 1, 0, 0);
        run_vec("R6 sub 16 signed", 64'h8000_7FFF_0000_1234, 64'h0001_FFFF_0001_1234, 2'd1, 1, 1, 0);
    endtask

    task automatic t_flags_R7;
        run_vec("R7 flags no sat", 64'h7F00_80FF_0000_0000, 64'h0100_FF01_0000_0000, 2'd0, 0, 1, 0);
        run_vec("R7 flags 16 unsigned", 64'hFFFF_0001_8000_0000, 64'h0001_0001_8000_0000, 2'd1, 0, 0, 0);
    endtask

    task automatic t_ssat_R8;
        run_vec("R8 pos clamp 8", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 0, 1, 1);
        run_vec("R8 neg clamp 8", 64'h8080_8080_8080_8080, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 0, 1, 1);
        run_vec("R8 sub clamp 32", 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'd2, 1, 1, 1);
    endtask

    task automatic t_usat_R9;
        run_vec("R9 add ones 16", 64'hFFF0_0001_8000_1234, 64'h0020_0001_8000_0001, 2'd1, 0, 0, 1);
        run_vec("R9 sub zero 8", 64'h0010_2030_4050_6070, 64'h2000_1040_3060_5080, 2'd0, 1, 0, 1);
    endtask

    task automatic t_full_R10;
        run_vec("R10 64 add carry", 64'h0000_0000_FFFF_FFFF, 64'h1, 2'd3, 0, 0, 0);
        run_vec("R10 64 signed sat", 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'd3, 0, 1, 1);
        run_vec("R10 64 unsigned sub", 64'h5, 64'h9, 2'd3, 1, 0, 1);
    endtask

    task automatic t_sweep_R5;
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 300; i++) begin
            logic [63:0] xa, xb;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); xa = s;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); xb = s;
            run_vec("R5 sweep", xa, xb, s[1:0], s[2], s[3], s[4]);
        end
    endtask

    initial begin
        t_reset_R1;
        t_latency_R2;
        t_isolation_R4;
        t_wrap_R5;
        t_sub_R6;
        t_flags_R7;
        t_ssat_R8;
        t_usat_R9;
        t_full_R10;
        t_sweep_R5;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule